// File: doc/BRIEF.md
# Configuration Address/Data Bridge

This block gives a host two small register ports for reaching device configuration space. The address port holds a latched 32-bit selector that names a bus, a device/function and a register offset. Its top bit acts as an enable. Accesses to the data port are turned into single configuration read or write requests toward a bank of device configuration spaces.

Before any request is issued, the bridge looks the target up through a combinational probe interface. The probe reports whether the target is present, whether it was added at runtime, how large its configuration space is, and whether function 0 of the same device is present. Missing, out-of-range or hidden targets are treated as master aborts and complete locally. A read that aborts returns all ones, and a write that aborts is discarded. Access lengths are clipped so that a request never crosses the end of the target's configuration space. A parameter selects little-endian or big-endian byte order for both host ports.

Top module: `cfg_access_bridge`

## Requirements
- R1: The address register is written only by a write to the address port with port offset 0 and size 4 bytes. Every other write to that port leaves it unchanged. Reset clears it to zero.
- R2: A read of the address port, at any size, returns the whole 32-bit latched value.
- R3: When bit 31 of the address register is 0, a data-port write issues no downstream request and a data-port read returns 0xFFFFFFFF.
- R4: The target address is the address register ORed with data-port offset bits 1:0. Its fields are: bits 23:16 give the bus, bits 15:8 give the device/function, and bits 7:0 give the register offset, masked to CFG_SPACE-1. These fields appear on dn_bus_o, dn_devfn_o and dn_off_o.
- R5: If the probe reports no target at the decoded bus and device/function, the access is aborted: no request is issued, and a read returns 0xFFFFFFFF.
- R6: The effective limit is the smaller of probe_limit_i and CFG_SPACE. If the offset is at or above this limit, the access is aborted. Otherwise dn_len_o is the smaller of the access size and (limit minus offset).
- R7: A target is hidden when it was added at runtime (probe_hotplug_i=1), its function field (devfn bits 2:0) is non-zero, and function 0 of the same device (probe_fn0_devfn_o = devfn with bits 2:0 cleared) is absent. A hidden target is aborted. A function that was not added at runtime, or whose function 0 is present, stays visible.
- R8: With BIG_ENDIAN=1, the low `size` bytes of write data and of read data are byte-reversed at the host ports. This applies to both the address port and the data port. Sizes are 1, 2 or 4 bytes.
- R9: Every data-port access that is not aborted issues exactly one downstream request. dn_req_valid_o stays high with a stable payload until dn_req_ready_i is seen.
- R10: acc_ready_o is high only when the bridge is idle. acc_done_o pulses once per access. For a downstream access, the pulse comes in the same cycle as dn_rsp_valid_i, and acc_rdata_o then carries the response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Host access strobe |
| acc_ready_o | output | 1 | Bridge idle, access accepted |
| acc_sel_i | input | 1 | 0 selects the address port, 1 selects the data port |
| acc_we_i | input | 1 | Write access |
| acc_off_i | input | 2 | Byte offset within the selected port |
| acc_size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_wdata_i | input | 32 | Write data, right-justified |
| acc_done_o | output | 1 | Access completion pulse |
| acc_rdata_o | output | 32 | Read data, valid with acc_done_o |
| probe_bus_o | output | 8 | Decoded bus for the lookup |
| probe_devfn_o | output | 8 | Decoded device/function for the lookup |
| probe_fn0_devfn_o | output | 8 | Device/function of function 0 of the same device |
| probe_hit_i | input | 1 | Target present |
| probe_hotplug_i | input | 1 | Target was added at runtime |
| probe_limit_i | input | 9 | Target configuration space size in bytes |
| probe_fn0_hit_i | input | 1 | Function 0 of the target's device present |
| dn_req_valid_o | output | 1 | Downstream request valid |
| dn_req_ready_i | input | 1 | Downstream request accepted |
| dn_we_o | output | 1 | Downstream write |
| dn_bus_o | output | 8 | Downstream bus number |
| dn_devfn_o | output | 8 | Downstream device/function |
| dn_off_o | output | 8 | Downstream register offset |
| dn_len_o | output | 3 | Downstream length in bytes after clipping |
| dn_wdata_o | output | 32 | Downstream write data, little-endian |
| dn_rsp_valid_i | input | 1 | Downstream response valid |
| dn_rsp_rdata_i | input | 32 | Downstream read data |

## Verification
The hardest case to reach is length clipping at the limit. It only shows up when the lane bits ORed into the latched offset push an access to within a few bytes of a small, target-specific limit. The stimulus programs the address register with offsets just below that limit, both at 64 bytes and at 256 bytes, and then uses sub-dword lanes so the OR lands on the last bytes. The hidden-function rule needs a runtime-added, non-zero function whose function 0 is absent, so the stub bank includes that case next to its visible counterparts. A big-endian instance runs in lockstep on byte-reversed stimulus, so every access also checks the byte-order variant.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOCAL, ST_REQ, ST_RSP} xfer_state_e;

  typedef struct packed {
    logic        we;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [7:0]  off;
    logic [2:0]  len;
    logic [31:0] wdata;
  } cfg_req_t;

  // reverse the low sz bytes, leave the rest untouched
  function automatic logic [31:0] swap_bytes(input logic [31:0] v, input logic [2:0] sz);
    case (sz)
      3'd4:    return {v[7:0], v[15:8], v[23:16], v[31:24]};
      3'd2:    return {v[31:16], v[7:0], v[15:8]};
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  off_i,
  input  logic [2:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (wr_i && off_i == 2'd0 && size_i == 3'd4) q_o <= wdata_i;
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode #(
  parameter int CFG_SPACE = 256,
  localparam int LIM_W = $clog2(CFG_SPACE) + 1
) (
  input  logic [31:0]      addr_q_i,
  input  logic [1:0]       lane_i,
  input  logic [2:0]       size_i,
  input  logic             hit_i,
  input  logic             hot_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             fn0_hit_i,
  output logic [7:0]       bus_o,
  output logic [7:0]       devfn_o,
  output logic [7:0]       fn0_devfn_o,
  output logic [7:0]       off_o,
  output logic [2:0]       len_o,
  output logic             abort_o
);
  localparam logic [7:0]       OFF_MASK = 8'(CFG_SPACE - 1);
  localparam logic [LIM_W-1:0] SPACE_L  = LIM_W'(CFG_SPACE);

  logic [31:0]      tgt;
  logic [LIM_W-1:0] lim, off_l, room;
  logic             hidden;

  assign tgt         = addr_q_i | {30'b0, lane_i};
  assign bus_o       = tgt[23:16];
  assign devfn_o     = tgt[15:8];
  assign fn0_devfn_o = {tgt[15:11], 3'b000};
  assign off_o       = tgt[7:0] & OFF_MASK;

  assign lim    = (limit_i > SPACE_L) ? SPACE_L : limit_i;
  assign off_l  = LIM_W'(off_o);
  assign room   = lim - off_l;
  assign hidden = hot_i && (devfn_o[2:0] != 3'd0) && !fn0_hit_i;

  always_comb begin
    len_o = size_i;
    if (room < LIM_W'(size_i)) len_o = room[2:0];
  end

  assign abort_o = !tgt[31] || !hit_i || (lim <= off_l) || hidden;
endmodule

// File: rtl/cfg_xfer_fsm.sv
module cfg_xfer_fsm
  import cfg_bridge_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_valid_i,
  input  logic        acc_sel_i,
  input  logic        acc_we_i,
  input  logic [2:0]  acc_size_i,
  input  logic [31:0] acc_wdata_i,
  input  logic [31:0] addr_q_i,
  input  logic [7:0]  bus_i,
  input  logic [7:0]  devfn_i,
  input  logic [7:0]  off_i,
  input  logic [2:0]  len_i,
  input  logic        abort_i,
  input  logic        dn_req_ready_i,
  input  logic        dn_rsp_valid_i,
  input  logic [31:0] dn_rsp_rdata_i,
  output logic        acc_ready_o,
  output logic        acc_done_o,
  output logic [31:0] rdata_le_o,
  output logic [2:0]  size_q_o,
  output logic        addr_wr_o,
  output logic        dn_req_valid_o,
  output cfg_req_t    dn_req_o
);
  xfer_state_e state_q;
  logic [31:0] local_q;
  logic        accept;

  assign accept    = acc_valid_i && (state_q == ST_IDLE);
  assign addr_wr_o = accept && !acc_sel_i && acc_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      local_q  <= '0;
      size_q_o <= 3'd4;
      dn_req_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          size_q_o <= acc_size_i;
          if (!acc_sel_i) begin
            local_q <= acc_we_i ? 32'h0 : addr_q_i;
            state_q <= ST_LOCAL;
          end else if (abort_i) begin
            local_q <= 32'hFFFF_FFFF;
            state_q <= ST_LOCAL;
          end else begin
            dn_req_o <= '{we: acc_we_i, bus: bus_i, devfn: devfn_i, off: off_i,
                          len: len_i, wdata: acc_wdata_i};
            state_q  <= ST_REQ;
          end
        end
        ST_LOCAL: state_q <= ST_IDLE;
        ST_REQ:   if (dn_req_ready_i) state_q <= ST_RSP;
        ST_RSP:   if (dn_rsp_valid_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_ready_o    = (state_q == ST_IDLE);
  assign dn_req_valid_o = (state_q == ST_REQ);
  assign acc_done_o     = (state_q == ST_LOCAL) || (state_q == ST_RSP && dn_rsp_valid_i);
  assign rdata_le_o     = (state_q == ST_RSP) ? dn_rsp_rdata_i : local_q;
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int CFG_SPACE  = 256,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         acc_valid_i,
  output logic                         acc_ready_o,
  input  logic                         acc_sel_i,
  input  logic                         acc_we_i,
  input  logic [1:0]                   acc_off_i,
  input  logic [2:0]                   acc_size_i,
  input  logic [31:0]                  acc_wdata_i,
  output logic                         acc_done_o,
  output logic [31:0]                  acc_rdata_o,
  output logic [7:0]                   probe_bus_o,
  output logic [7:0]                   probe_devfn_o,
  output logic [7:0]                   probe_fn0_devfn_o,
  input  logic                         probe_hit_i,
  input  logic                         probe_hotplug_i,
  input  logic [$clog2(CFG_SPACE):0]   probe_limit_i,
  input  logic                         probe_fn0_hit_i,
  output logic                         dn_req_valid_o,
  input  logic                         dn_req_ready_i,
  output logic                         dn_we_o,
  output logic [7:0]                   dn_bus_o,
  output logic [7:0]                   dn_devfn_o,
  output logic [7:0]                   dn_off_o,
  output logic [2:0]                   dn_len_o,
  output logic [31:0]                  dn_wdata_o,
  input  logic                         dn_rsp_valid_i,
  input  logic [31:0]                  dn_rsp_rdata_i
);
  logic [31:0] wdata_le, rdata_le, addr_q;
  logic [2:0]  size_q, dec_len;
  logic [7:0]  dec_off;
  logic        dec_abort, addr_wr;
  cfg_req_t    req;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign wdata_le    = swap_bytes(acc_wdata_i, acc_size_i);
      assign acc_rdata_o = swap_bytes(rdata_le, size_q);
    end else begin : g_le
      assign wdata_le    = acc_wdata_i;
      assign acc_rdata_o = rdata_le;
    end
  endgenerate

  cfg_addr_reg u_areg (
    .clk_i, .rst_ni,
    .wr_i(addr_wr), .off_i(acc_off_i), .size_i(acc_size_i),
    .wdata_i(wdata_le), .q_o(addr_q)
  );

  cfg_decode #(.CFG_SPACE(CFG_SPACE)) u_dec (
    .addr_q_i(addr_q), .lane_i(acc_off_i), .size_i(acc_size_i),
    .hit_i(probe_hit_i), .hot_i(probe_hotplug_i), .limit_i(probe_limit_i),
    .fn0_hit_i(probe_fn0_hit_i),
    .bus_o(probe_bus_o), .devfn_o(probe_devfn_o), .fn0_devfn_o(probe_fn0_devfn_o),
    .off_o(dec_off), .len_o(dec_len), .abort_o(dec_abort)
  );

  cfg_xfer_fsm u_fsm (
    .clk_i, .rst_ni,
    .acc_valid_i, .acc_sel_i, .acc_we_i, .acc_size_i,
    .acc_wdata_i(wdata_le), .addr_q_i(addr_q),
    .bus_i(probe_bus_o), .devfn_i(probe_devfn_o), .off_i(dec_off),
    .len_i(dec_len), .abort_i(dec_abort),
    .dn_req_ready_i, .dn_rsp_valid_i, .dn_rsp_rdata_i,
    .acc_ready_o, .acc_done_o, .rdata_le_o(rdata_le), .size_q_o(size_q),
    .addr_wr_o(addr_wr), .dn_req_valid_o, .dn_req_o(req)
  );

  assign dn_we_o    = req.we;
  assign dn_bus_o   = req.bus;
  assign dn_devfn_o = req.devfn;
  assign dn_off_o   = req.off;
  assign dn_len_o   = req.len;
  assign dn_wdata_o = req.wdata;
endmodule

// File: rtl/cfg_access_bridge_chk.sv
module cfg_access_bridge_chk #(
  parameter int CFG_SPACE = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        acc_ready_o,
  input logic        acc_done_o,
  input logic        dn_req_valid_o,
  input logic        dn_req_ready_i,
  input logic [7:0]  dn_bus_o,
  input logic [7:0]  dn_devfn_o,
  input logic [7:0]  dn_off_o,
  input logic [2:0]  dn_len_o,
  input logic [31:0] addr_q
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_valid_o && !dn_req_ready_i |=> dn_req_valid_o && $stable(dn_off_o) &&
      $stable(dn_len_o) && $stable(dn_bus_o) && $stable(dn_devfn_o));

  // R3
  req_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_valid_o |-> addr_q[31]);

  // R6
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_valid_o |-> dn_len_o != 3'd0 && dn_len_o <= 3'd4 &&
      (10'(dn_off_o) + 10'(dn_len_o) <= 10'(CFG_SPACE)));

  // R10
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done_o |-> !acc_ready_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_done_o |=> !acc_done_o);

  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ready_o |=> $stable(addr_q));
endmodule

bind cfg_access_bridge cfg_access_bridge_chk #(.CFG_SPACE(CFG_SPACE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_ready_o(acc_ready_o), .acc_done_o(acc_done_o),
  .dn_req_valid_o(dn_req_valid_o), .dn_req_ready_i(dn_req_ready_i),
  .dn_bus_o(dn_bus_o), .dn_devfn_o(dn_devfn_o), .dn_off_o(dn_off_o),
  .dn_len_o(dn_len_o), .addr_q(addr_q)
);

// File: tb/cfg_access_bridge_test.sv
module cfg_access_bridge_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        acc_valid = 0, acc_sel = 0, acc_we = 0;
  logic [1:0]  acc_off = 0;
  logic [2:0]  acc_size = 4;
  logic [31:0] acc_wdata = 0, acc_wdata_be = 0;
  logic        dn_ready = 0, rsp_valid = 0;
  logic [31:0] rsp_data = 0;
  logic        p_hit, p_hot, p_f0;
  logic [8:0]  p_lim;

  logic        rdy, done, rdy_b, done_b;
  logic [31:0] rdata, rdata_b;
  logic [7:0]  pbus, pdf, pf0, pbus_b, pdf_b, pf0_b;
  logic        dv, dwe, dv_b, dwe_b;
  logic [7:0]  dbus, ddf, doff, dbus_b, ddf_b, doff_b;
  logic [2:0]  dlen, dlen_b;
  logic [31:0] dwd, dwd_b;

  cfg_access_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_ready_o(rdy),
    .acc_sel_i(acc_sel), .acc_we_i(acc_we), .acc_off_i(acc_off), .acc_size_i(acc_size),
    .acc_wdata_i(acc_wdata), .acc_done_o(done), .acc_rdata_o(rdata),
    .probe_bus_o(pbus), .probe_devfn_o(pdf), .probe_fn0_devfn_o(pf0),
    .probe_hit_i(p_hit), .probe_hotplug_i(p_hot), .probe_limit_i(p_lim), .probe_fn0_hit_i(p_f0),
    .dn_req_valid_o(dv), .dn_req_ready_i(dn_ready), .dn_we_o(dwe), .dn_bus_o(dbus),
    .dn_devfn_o(ddf), .dn_off_o(doff), .dn_len_o(dlen), .dn_wdata_o(dwd),
    .dn_rsp_valid_i(rsp_valid), .dn_rsp_rdata_i(rsp_data));

  cfg_access_bridge #(.BIG_ENDIAN(1'b1)) uut_be (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_ready_o(rdy_b),
    .acc_sel_i(acc_sel), .acc_we_i(acc_we), .acc_off_i(acc_off), .acc_size_i(acc_size),
    .acc_wdata_i(acc_wdata_be), .acc_done_o(done_b), .acc_rdata_o(rdata_b),
    .probe_bus_o(pbus_b), .probe_devfn_o(pdf_b), .probe_fn0_devfn_o(pf0_b),
    .probe_hit_i(p_hit), .probe_hotplug_i(p_hot), .probe_limit_i(p_lim), .probe_fn0_hit_i(p_f0),
    .dn_req_valid_o(dv_b), .dn_req_ready_i(dn_ready), .dn_we_o(dwe_b), .dn_bus_o(dbus_b),
    .dn_devfn_o(ddf_b), .dn_off_o(doff_b), .dn_len_o(dlen_b), .dn_wdata_o(dwd_b),
    .dn_rsp_valid_i(rsp_valid), .dn_rsp_rdata_i(rsp_data));

  // device bank stub, bus 0 only
  logic dev_hit [256];
  logic dev_hot [256];
  int   dev_lim [256];
  always_comb begin
    p_hit = (pbus == 8'd0) && dev_hit[pdf];
    p_hot = dev_hot[pdf];
    p_lim = 9'(dev_lim[pdf]);
    p_f0  = (pbus == 8'd0) && dev_hit[pf0];
  end

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_addr = 0;
  bit in_acc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] v, input int sz);
    if (sz == 4) return {v[7:0], v[15:8], v[23:16], v[31:24]};
    if (sz == 2) return {v[31:16], v[7:0], v[15:8]};
    return v;
  endfunction

  function automatic logic [31:0] rsp_of(input logic [7:0] df, input logic [7:0] o, input logic [2:0] l);
    return {8'hC5, df, o, 5'b0, l};
  endfunction

  // completion seen outside an access is a failure, checked each clock
  always @(negedge clk) if (rst_n && done && !in_acc) chk(0, "R10 stray done", 1, 0);

  task automatic access(input bit sel, input bit we, input int off, input int size,
                        input logic [31:0] wd, input string req);
    logic [31:0] a, exp_rd, rd, rd_b;
    logic [7:0]  bus, df, o, xo;
    int lim, len, nreq, xl;
    bit en, hit, hidden, abort, got;
    logic xwe, xbus_ok, xdf_ok;
    logic [31:0] xwd;
    a = m_addr | 32'(off);
    en = a[31]; bus = a[23:16]; df = a[15:8]; o = a[7:0];
    hit = (bus == 0) && dev_hit[df];
    lim = (dev_lim[df] > 256) ? 256 : dev_lim[df];
    hidden = dev_hot[df] && (df[2:0] != 0) && !dev_hit[{df[7:3], 3'b000}];
    abort = !en || !hit || (lim <= int'(o)) || hidden;
    len = (lim - int'(o) < size) ? lim - int'(o) : size;
    if (!sel) exp_rd = m_addr;
    else if (abort) exp_rd = 32'hFFFF_FFFF;
    else exp_rd = rsp_of(df, o, 3'(len));

    @(negedge clk);
    chk(rdy && rdy_b, "R10 idle ready", 32'(rdy), 1);
    in_acc = 1;
    acc_valid = 1; acc_sel = sel; acc_we = we; acc_off = 2'(off); acc_size = 3'(size);
    acc_wdata = wd; acc_wdata_be = bswap(wd, size);
    @(negedge clk);
    acc_valid = 0;
    nreq = 0; got = 0; rd = 0; rd_b = 0; xo = 0; xl = 0; xwe = 0; xwd = 0;
    xbus_ok = 1; xdf_ok = 1;
    for (int c = 0; c < 40 && !got; c++) begin
      if (done) begin
        rd = rdata; rd_b = rdata_b; got = 1;
        chk(done_b, {req, " be done"}, 32'(done_b), 1);
      end else if (dv) begin
        nreq++;
        xo = doff; xl = int'(dlen); xwe = dwe; xwd = dwd;
        xbus_ok = (dbus == bus); xdf_ok = (ddf == df);
        chk(dv_b && dwd_b == dwd && doff_b == doff, {req, " R8 be request"}, dwd_b, dwd);
        @(negedge clk);
        chk(dv && doff == xo && 32'(dlen) == 32'(xl), {req, " R9 hold"}, 32'(doff), 32'(xo));
        dn_ready = 1;
        @(negedge clk);
        dn_ready = 0;
        chk(!done && !dv, {req, " R10 wait rsp"}, 32'(done), 0);
        @(negedge clk);
        rsp_valid = 1; rsp_data = rsp_of(ddf, doff, dlen);
        #1;
        chk(done, {req, " R10 same-cycle done"}, 32'(done), 1);
        rd = rdata; rd_b = rdata_b; got = 1;
        @(negedge clk);
        rsp_valid = 0;
        chk(!dv && !done, {req, " R9 single request"}, 32'(dv), 0);
      end else @(negedge clk);
    end
    chk(got, {req, " completion"}, 32'(got), 1);
    if (sel && !abort) begin
      chk(nreq == 1, {req, " R9 one request"}, 32'(nreq), 1);
      chk(xbus_ok && xdf_ok && xo == o, {req, " R4 fields"}, 32'(xo), 32'(o));
      chk(xl == len, {req, " R6 len"}, 32'(xl), 32'(len));
      chk(xwe == we, {req, " dir"}, 32'(xwe), 32'(we));
      if (we) chk(xwd == wd, {req, " wdata"}, xwd, wd);
    end else chk(nreq == 0, {req, " no request"}, 32'(nreq), 0);
    if (!we) begin
      chk(rd == exp_rd, {req, " rdata"}, rd, exp_rd);
      chk(rd_b == bswap(exp_rd, size), {req, " R8 be rdata"}, rd_b, bswap(exp_rd, size));
    end
    if (!sel && we && off == 0 && size == 4) m_addr = wd;
    @(negedge clk);
    in_acc = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin dev_hit[i] = 0; dev_hot[i] = 0; dev_lim[i] = 256; end
    dev_hit[8'h08] = 1;
    dev_hit[8'h0A] = 1; dev_hot[8'h0A] = 1;
    dev_hit[8'h13] = 1; dev_hot[8'h13] = 1;
    dev_hit[8'h18] = 1; dev_lim[8'h18] = 64;
    dev_hit[8'h19] = 1;
    dev_hit[8'h21] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdy && !dv && !done, "R10 reset state", 32'(rdy), 1);
    access(0, 0, 0, 4, 0, "R2 reset addr zero");
    // R3: enable clear
    access(1, 0, 0, 4, 0, "R3 read disabled");
    access(1, 1, 2, 2, 32'hBEEF, "R3 write disabled");
    // R1: rejected address writes
    access(0, 1, 0, 2, 32'h8000_0810, "R1 size2 ignored");
    access(0, 1, 1, 4, 32'h8000_0810, "R1 off1 ignored");
    access(0, 0, 0, 4, 0, "R1 still zero");
    access(0, 1, 0, 4, 32'h8000_0810, "R1 full write");
    access(0, 0, 2, 1, 0, "R2 byte read full value");
    // R4: decode and lanes
    access(1, 0, 0, 4, 0, "R4 dword read");
    access(1, 0, 3, 1, 0, "R4 byte lane 3");
    access(1, 1, 2, 2, 32'h0000_1234, "R4 half write lane 2");
    access(0, 1, 0, 4, 32'h8000_0811, "R1 set low offset bits");
    access(1, 0, 2, 1, 0, "R4 lane OR offset");
    access(0, 1, 0, 4, 32'h8000_08FC, "R1 near top");
    access(1, 0, 3, 4, 0, "R6 clip at 256");
    // R5: absent targets
    access(0, 1, 0, 4, 32'h8001_0800, "R1 bus1");
    access(1, 0, 0, 4, 0, "R5 no bus");
    access(0, 1, 0, 4, 32'h8000_3000, "R1 devfn 30");
    access(1, 1, 0, 4, 32'h1111_2222, "R5 no device write");
    access(1, 0, 1, 2, 0, "R5 no device read");
    // R6: small limit
    access(0, 1, 0, 4, 32'h8000_183C, "R1 dev3 3C");
    access(1, 0, 0, 4, 0, "R6 exact fit");
    access(1, 0, 2, 4, 0, "R6 clipped to 2");
    access(1, 1, 2, 2, 32'h0000_ABCD, "R6 half at end");
    access(0, 1, 0, 4, 32'h8000_1840, "R1 dev3 40");
    access(1, 0, 0, 1, 0, "R6 beyond limit read");
    access(1, 1, 0, 4, 32'h5555_AAAA, "R6 beyond limit write");
    // R7: hidden functions
    access(0, 1, 0, 4, 32'h8000_0A04, "R1 dev1 fn2");
    access(1, 0, 0, 4, 0, "R7 hotplug with fn0 visible");
    access(0, 1, 0, 4, 32'h8000_1304, "R1 dev2 fn3");
    access(1, 0, 0, 4, 0, "R7 hidden read");
    access(1, 1, 0, 4, 32'h7777_8888, "R7 hidden write");
    access(0, 1, 0, 4, 32'h8000_2100, "R1 dev4 fn1");
    access(1, 0, 1, 2, 0, "R7 cold fn without fn0 visible");
    access(0, 1, 0, 4, 32'h8000_1904, "R1 dev3 fn1");
    access(1, 1, 0, 4, 32'hCAFE_F00D, "R7 plain fn1 write");
    // R3 after clearing enable with a target that exists
    access(0, 1, 0, 4, 32'h0000_0810, "R1 disable");
    access(1, 0, 0, 4, 0, "R3 read disabled present");
    access(0, 0, 0, 2, 0, "R2 half read");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule